// File: doc/BRIEF.md
# External Pin Interrupt Unit

This peripheral turns up to seven external pins into interrupt requests for a downstream interrupt controller. Each pin can be used as a plain general-purpose I/O line or as an interrupt source. For every line, software picks whether it senses a low level or a rising, falling or either edge. It also sets whether the pad is driven and whether the line may raise its request. Edge events are caught in a pending-flag register. Software acknowledges an edge interrupt by writing a one to that flag bit.

Software reaches the block through a synchronous 16-bit register bus with two byte strobes. Pad inputs pass through a two-stage synchronizer before any sensing or read-back. Line 0 has a slot in every register but is reserved: it works as a GPIO bit and never asserts a request. The block has no priority logic, no vectoring and no CPU interface apart from this bus.

Top module: `eport_irq_unit`

## Requirements
- R1: After reset every register reads zero: all lines are level-sensitive inputs, interrupts are disabled, flags are clear, `pad_oe` is zero and no request is asserted.
- R2: The bus selects a halfword with `reg_sel`. `reg_be[1]` writes `reg_wdata[15:8]` and `reg_be[0]` writes `reg_wdata[7:0]`. Select 0 is the 16-bit sense register, with line n's field at bits [2n+1:2n]. Select 1 holds direction in the high byte and interrupt enable in the low byte. Select 2 holds data-out in the high byte and the read-only pin state in the low byte. Select 3 holds the flags in the high byte, and its low byte reads zero. Each register reads back what was written, with no delay through `reg_rdata`.
- R3: `pad_oe` equals the direction register (a bit set to 1 drives the pad) and `pad_out` equals the data-out register.
- R4: The pin-state byte shows `pad_in` delayed by exactly two clock edges.
- R5: The sense field encodes 00 = low level, 01 = rising edge, 10 = falling edge, 11 = either edge. In an edge mode, an edge seen on the synchronized pin sets the line's flag one cycle after it is detected. In level mode the flag is never set.
- R6: Writing 1 to a flag bit (select 3, high byte) clears it, and writing 0 leaves it alone. If an edge sets a bit in the same cycle that a write clears it, the set wins.
- R7: In an edge mode, line n's request is flag AND enable AND (direction bit = 0).
- R8: In level mode, line n's request is enable AND (direction = 0) AND (synchronized pin low). It does not depend on the flag, and a clear write to the flag has no effect on it.
- R9: Line 0 never sets its flag (select 3 bit 8 reads 0) and has no request output, whatever its sense, enable or pin activity.
- R10: A line whose direction bit is 1 still latches edge flags from the pad value, but its request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Halfword register select |
| reg_we | input | 1 | Write enable |
| reg_be | input | 2 | Byte strobes: bit 1 high byte, bit 0 low byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected halfword |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| irq_req | output | 7 | Request for lines 7..1 (bit n = line n) |

## Verification
The bench builds the block with its default values: eight line slots and a two-stage synchronizer. This covers all seven live lines, the reserved line 0, both full byte lanes of every register and the exact two-edge pin latency. With that setup, directed cases can line up a clear write with the edge-detect cycle on purpose to test which one wins. The pad loopback in the bench lets a driven line create its own edges.

// File: rtl/eport_pkg.sv
package eport_pkg;

    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'b00,
        SENSE_RISE  = 2'b01,
        SENSE_FALL  = 2'b10,
        SENSE_BOTH  = 2'b11
    } sense_e;

    localparam logic [1:0] SEL_SENSE = 2'd0;
    localparam logic [1:0] SEL_CTRL  = 2'd1;
    localparam logic [1:0] SEL_DATA  = 2'd2;
    localparam logic [1:0] SEL_FLAG  = 2'd3;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/eport_sync.sv
module eport_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d;
    logic [STAGES-1:0][W-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/eport_regs.sv
module eport_regs
    import eport_pkg::*;
#(
    parameter int NL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel_i,
    input  logic              we_i,
    input  logic [1:0]        be_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [NL-1:0]     pin_i,
    input  logic [NL-1:0]     flag_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic [2*NL-1:0]   sense_o,
    output logic [NL-1:0]     dir_o,
    output logic [NL-1:0]     ien_o,
    output logic [NL-1:0]     dout_o,
    output logic [NL-1:0]     flag_clr_o
);
    localparam int SW = 2 * NL;
    localparam int HI = BYTE_W;

    typedef struct packed {
        logic [SW-1:0] sense;
        logic [NL-1:0] dir;
        logic [NL-1:0] ien;
        logic [NL-1:0] dout;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d     = regs_q;
        flag_clr_o = '0;
        if (we_i) begin
            unique case (sel_i)
                SEL_SENSE: begin
                    for (int i = 0; i < SW; i++) begin
                        if (be_i[i/BYTE_W]) regs_d.sense[i] = wdata_i[i];
                    end
                end
                SEL_CTRL: begin
                    if (be_i[1]) regs_d.dir = wdata_i[HI +: NL];
                    if (be_i[0]) regs_d.ien = wdata_i[0 +: NL];
                end
                SEL_DATA: begin
                    if (be_i[1]) regs_d.dout = wdata_i[HI +: NL];
                end
                SEL_FLAG: begin
                    if (be_i[1]) flag_clr_o = wdata_i[HI +: NL];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel_i)
            SEL_SENSE: rdata_o[SW-1:0] = regs_q.sense;
            SEL_CTRL: begin
                rdata_o[HI +: NL] = regs_q.dir;
                rdata_o[0 +: NL]  = regs_q.ien;
            end
            SEL_DATA: begin
                rdata_o[HI +: NL] = regs_q.dout;
                rdata_o[0 +: NL]  = pin_i;
            end
            SEL_FLAG: rdata_o[HI +: NL] = flag_i;
            default: ;
        endcase
    end

    assign sense_o = regs_q.sense;
    assign dir_o   = regs_q.dir;
    assign ien_o   = regs_q.ien;
    assign dout_o  = regs_q.dout;

    // R2: a strobed control write shows on the register outputs one edge later
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_CTRL && be_i[1]) |=> (dir_o == $past(wdata_i[HI +: NL])));

    // R2: without its strobe the enable byte holds
    a_r2_ien_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && sel_i == SEL_CTRL && be_i[0]) |=> $stable(ien_o));

endmodule

// File: rtl/eport_line.sv
module eport_line
    import eport_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode_i,
    input  logic   en_i,
    input  logic   dir_i,
    input  logic   pin_i,
    input  logic   clr_i,
    output logic   flag_o,
    output logic   irq_o
);
    typedef struct packed {
        logic prev;
        logic flag;
    } line_t;

    line_t line_d, line_q;
    logic  rise_w, fall_w, set_w;

    always_comb begin
        rise_w = pin_i & ~line_q.prev;
        fall_w = ~pin_i & line_q.prev;
        unique case (mode_i)
            SENSE_RISE:  set_w = rise_w;
            SENSE_FALL:  set_w = fall_w;
            SENSE_BOTH:  set_w = rise_w | fall_w;
            default:     set_w = 1'b0;
        endcase
        line_d.prev = pin_i;
        line_d.flag = set_w | (line_q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    always_comb begin
        if (en_i && !dir_i) begin
            irq_o = (mode_i == SENSE_LEVEL) ? ~pin_i : line_q.flag;
        end else begin
            irq_o = 1'b0;
        end
    end

    assign flag_o = line_q.flag;

    // R6: an edge that coincides with a clear still leaves the flag set
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_w |=> flag_o);

    // R6: a clear with no competing edge empties the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_w) |=> !flag_o);

    // R5: level mode never raises the flag
    a_r5_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_LEVEL && !flag_o) |=> !flag_o);

    // R10: a driven line never requests
    a_r10_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dir_i |-> !irq_o);

    // R8: low level on an enabled input requests regardless of the flag
    a_r8_level_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_LEVEL && en_i && !dir_i && !pin_i) |-> irq_o);

endmodule

// File: rtl/eport_irq_unit.sv
module eport_irq_unit
    import eport_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           reg_sel,
    input  logic                 reg_we,
    input  logic [1:0]           reg_be,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_LINES-1:1] irq_req
);
    localparam int NL = NUM_LINES;
    localparam int SW = 2 * NL;

    logic [NL-1:0] pin_sync;
    logic [SW-1:0] sense;
    logic [NL-1:0] dir, ien, dout, flag_clr, flags;

    eport_sync #(.W(NL), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pin_sync)
    );

    eport_regs #(.NL(NL)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (reg_sel),
        .we_i       (reg_we),
        .be_i       (reg_be),
        .wdata_i    (reg_wdata),
        .pin_i      (pin_sync),
        .flag_i     (flags),
        .rdata_o    (reg_rdata),
        .sense_o    (sense),
        .dir_o      (dir),
        .ien_o      (ien),
        .dout_o     (dout),
        .flag_clr_o (flag_clr)
    );

    // line 0 is reserved: no sensing, no flag, no request
    assign flags[0] = 1'b0;

    for (genvar g = 1; g < NL; g++) begin : g_line
        eport_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (sense_e'(sense[2*g +: 2])),
            .en_i   (ien[g]),
            .dir_i  (dir[g]),
            .pin_i  (pin_sync[g]),
            .clr_i  (flag_clr[g]),
            .flag_o (flags[g]),
            .irq_o  (irq_req[g])
        );
    end

    assign pad_oe  = dir;
    assign pad_out = dout;

    logic unused_line0;
    assign unused_line0 = ^{sense[1:0], ien[0], flag_clr[0]};

    // cycles since reset, for the latency check below
    logic [1:0] chk_cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_cyc_q <= '0;
        end else if (chk_cyc_q != 2'd3) begin
            chk_cyc_q <= chk_cyc_q + 2'd1;
        end
    end

    if (SYNC_STAGES == 2) begin : g_lat_chk
        // R4: pin-state byte lags the pads by two edges
        a_r4_pin_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_sel == SEL_DATA && chk_cyc_q == 2'd3)
                |-> (reg_rdata[NL-1:0] == $past(pad_in, 2)));
    end

    // R9: reserved line never shows a flag
    a_r9_line0_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_FLAG) |-> !reg_rdata[8]);

endmodule

// File: tb/eport_irq_unit_tb.sv
`timescale 1ns/1ps
module eport_irq_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  ext_pad = '0;
    logic [7:0]  pad_in_w, pad_out, pad_oe;
    logic [7:1]  irq_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    // pad loopback: driven lines see their own output
    assign pad_in_w = (pad_oe & pad_out) | (~pad_oe & ext_pad);

    eport_irq_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in_w),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_req   (irq_req)
    );

    // ---------------- behavioural reference ----------------
    logic [15:0] m_sense = '0;
    logic [7:0]  m_dir = '0, m_ien = '0, m_dout = '0, m_flag = '0;
    logic [7:0]  m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [7:0]  m_clr, m_set;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sense = '0; m_dir = '0; m_ien = '0; m_dout = '0; m_flag = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            m_clr = (reg_we && reg_sel == 2'd3 && reg_be[1]) ? reg_wdata[15:8] : 8'h00;
            m_set = '0;
            for (int n = 1; n < 8; n++) begin
                case (m_sense[2*n +: 2])
                    2'b01: m_set[n] = m_s2[n] && !m_prev[n];
                    2'b10: m_set[n] = !m_s2[n] && m_prev[n];
                    2'b11: m_set[n] = m_s2[n] != m_prev[n];
                    default: m_set[n] = 1'b0;
                endcase
            end
            m_flag = m_set | (m_flag & ~m_clr);
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad_in_w;
            if (reg_we) begin
                case (reg_sel)
                    2'd0: begin
                        if (reg_be[0]) m_sense[7:0]  = reg_wdata[7:0];
                        if (reg_be[1]) m_sense[15:8] = reg_wdata[15:8];
                    end
                    2'd1: begin
                        if (reg_be[1]) m_dir = reg_wdata[15:8];
                        if (reg_be[0]) m_ien = reg_wdata[7:0];
                    end
                    2'd2: if (reg_be[1]) m_dout = reg_wdata[15:8];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic exp_irq(int n);
        if (!m_ien[n] || m_dir[n]) return 1'b0;
        if (m_sense[2*n +: 2] == 2'b00) return !m_s2[n];
        return m_flag[n];
    endfunction

    function automatic logic [15:0] exp_rdata();
        case (reg_sel)
            2'd0: return m_sense;
            2'd1: return {m_dir, m_ien};
            2'd2: return {m_dout, m_s2};
            default: return {m_flag, 8'h00};
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(posedge clk) begin
        #2;
        if (!finished) begin
            for (int n = 1; n < 8; n++) begin
                chk((m_sense[2*n +: 2] == 2'b00) ? "R8 level irq" : "R7 edge irq",
                    {15'd0, irq_req[n]}, {15'd0, exp_irq(n)});
            end
            case (reg_sel)
                2'd2:    chk("R4 pin/data read", reg_rdata, exp_rdata());
                2'd3:    chk("R5 flag read", reg_rdata, exp_rdata());
                default: chk("R2 reg read", reg_rdata, exp_rdata());
            endcase
            chk("R3 pad drive", {pad_oe, pad_out}, {m_dir, m_dout});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(logic [1:0] sel, logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; reg_be = be; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_be = '0;
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=timeout exp=done");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s);
            idle(1);
            chk("R1 reset read", reg_rdata, 16'h0000);
        end
        chk("R1 reset irq/oe", {1'b0, irq_req, pad_oe}, 16'h0000);

        // R2: byte strobes
        wr(2'd1, 2'b01, 16'hAA55);
        reg_sel = 2'd1; idle(1);
        chk("R2 low strobe only", reg_rdata, 16'h0055);
        wr(2'd0, 2'b10, 16'h1234);
        reg_sel = 2'd0; idle(1);
        chk("R2 sense high byte", reg_rdata, 16'h1200);

        // sense: l7=11 l6=10 l5=01 l4=00 l3=11 l2=10 l1=01 l0=11
        wr(2'd0, 2'b11, 16'hE4E7);
        wr(2'd1, 2'b11, 16'h00FF);

        // R4: two-edge pin latency
        reg_sel = 2'd2; idle(1);
        ext_pad = 8'h5A;
        idle(1);
        chk("R4 not yet visible", {8'h00, reg_rdata[7:0]}, 16'h0000);
        idle(1);
        chk("R4 visible after two edges", {8'h00, reg_rdata[7:0]}, 16'h005A);

        // R8: line 4 level, pad low -> request; clear write does not change it
        ext_pad = 8'hEF;
        idle(3);
        chk("R8 level low requests", {15'd0, irq_req[4]}, 16'd1);
        wr(2'd3, 2'b10, 16'hFF00);
        idle(1);
        chk("R8 unaffected by clear", {15'd0, irq_req[4]}, 16'd1);
        ext_pad = 8'hFF;
        idle(3);
        chk("R8 level high releases", {15'd0, irq_req[4]}, 16'd0);
        reg_sel = 2'd3; idle(1);
        chk("R5 level line sets no flag", {15'd0, reg_rdata[12]}, 16'd0);

        // R5: falling edge on line 2
        wr(2'd3, 2'b10, 16'hFF00);
        reg_sel = 2'd3;
        ext_pad = 8'hFB;
        idle(4);
        chk("R5 falling edge flag", {15'd0, reg_rdata[10]}, 16'd1);
        chk("R7 edge request", {15'd0, irq_req[2]}, 16'd1);

        // R6: clear write coinciding with set -> set wins
        ext_pad = 8'h00;
        idle(4);
        wr(2'd3, 2'b10, 16'hFF00);
        idle(2);
        ext_pad = 8'h02;
        idle(1);
        @(negedge clk);
        reg_sel = 2'd3; reg_be = 2'b10; reg_wdata = 16'h0200; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_be = '0;
        chk("R6 set wins over clear", {15'd0, reg_rdata[9]}, 16'd1);
        wr(2'd3, 2'b10, 16'h0200);
        reg_sel = 2'd3; idle(1);
        chk("R6 write-one clears", {15'd0, reg_rdata[9]}, 16'd0);

        // R9: line 0 toggling never flags
        for (int t = 0; t < 4; t++) begin
            ext_pad[0] = ~ext_pad[0];
            idle(3);
        end
        chk("R9 line0 flag stays 0", {15'd0, reg_rdata[8]}, 16'd0);

        // R10: driven line 5 latches an edge but does not request
        ext_pad = 8'h00;
        wr(2'd1, 2'b10, 16'h2000);
        idle(3);
        wr(2'd3, 2'b10, 16'hFF00);
        wr(2'd2, 2'b10, 16'h2000);
        reg_sel = 2'd3;
        idle(5);
        chk("R10 driven line flag set", {15'd0, reg_rdata[13]}, 16'd1);
        chk("R10 driven line no request", {15'd0, irq_req[5]}, 16'd0);
        chk("R3 pad_oe follows direction", {8'h00, pad_oe}, 16'h0020);

        // mixed traffic checked every cycle against the reference
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            ext_pad = 8'($urandom);
            reg_sel = 2'($urandom);
            reg_we  = ($urandom % 4) == 0;
            reg_be  = 2'($urandom);
            reg_wdata = 16'($urandom);
            if (reg_we && reg_sel == 2'd1 && (c % 3) != 0) reg_wdata[15:8] = 8'h00;
        end
        @(negedge clk);
        reg_we = 1'b0;
        idle(4);

        finished = 1;
        summary();
        $finish;
    end

endmodule